// File: doc/BRIEF.md
# Fused Multiply-Add Significand Engine

This block computes the exact, not yet rounded, result of `z + (±x·y)` for finite single-precision operands. The caller supplies three normalized 24-bit significands with the hidden bit set, their unbiased exponents, the effective sign of the product, the sign of the addend, a flag saying the addend is zero, and a flag selecting round-toward-negative. The engine returns a sign, an exponent, a 27-bit significand and an exact-zero flag. The significand carries the hidden one in its top bit and guard, round and sticky in its low three bits. A later rounding and packing stage consumes these outputs.

Internally the full 48-bit product and the addend share a 64-bit word format with the leading one at bit 62. Each right shift ORs the lost bits into bit 0, so information lost before the single final rounding survives as sticky. The work is spread over a short sequence of states with a register between stages. The state sequence is `ST_IDLE` → `ST_MUL` → `ST_ALIGN` → `ST_MERGE` → `ST_NORM` → `ST_DONE` → `ST_IDLE`. The only conditional transition is `ST_IDLE` → `ST_MUL`, taken when `start` is high. Every other transition happens unconditionally on the next clock edge.

- `ST_MUL` forms and places the product.
- `ST_ALIGN` shifts the operand with the smaller exponent.
- `ST_MERGE` adds or subtracts.
- `ST_NORM` normalizes and converts the result to the 27-bit output form.
- `ST_DONE` presents the result.

Top module: `fma_sig_core`

## Requirements
- R1: The product exponent is `x_exp + y_exp`. When the 48-bit product has its top bit set (significand product of 2 or more), the exponent is one higher and the significand is renormalized, so 1.5·1.5 with zero exponents gives exponent 1 and `res_sig` = 0x4800000.
- R2: When `z_zero` is high, the result is the product alone. Its sign is `prod_neg`, its exponent is the product exponent, and `z_sig`, `z_exp` and `z_neg` have no effect.
- R3: The operand with the smaller exponent is shifted right by the exponent difference. Any ones shifted below output precision set the sticky bit (`res_sig[0]`).
- R4: An alignment distance of 63 or more reduces the shifted operand to a lone sticky bit. This holds whichever operand is the smaller one.
- R5: With `prod_neg == z_neg` the magnitudes are added. A carry out of the leading position raises the exponent by one and the result stays normalized.
- R6: With `prod_neg != z_neg` the smaller magnitude is subtracted from the larger one. The result sign is the sign of the larger one.
- R7: An exact-zero difference gives `res_zero` = 1, `res_sig` = 0 and `res_exp` = 0. `res_neg` then equals `rnd_down`.
- R8: After a subtraction the result is shifted left until its leading one reaches the top significand bit. The exponent drops by one for every position shifted, by as many as 23 or more positions.
- R9: A nonzero result has `res_sig[26]` = 1. Bits 2..0 are guard, round and sticky, and bit 0 is set when any lower-order bit was nonzero.
- R10: `start` is sampled only in `ST_IDLE`. `done` is high for exactly one cycle, four clock edges after the edge that accepted `start`. A `start` pulse while `busy` is high is ignored. The result outputs change only on entry to `ST_DONE` and hold afterwards.
- R11: During and just after reset `busy`, `done`, `res_neg`, `res_exp`, `res_sig` and `res_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in `ST_IDLE`) |
| x_sig | input | 24 | Multiplicand significand, hidden bit at 23 |
| x_exp | input | 10 | Multiplicand unbiased exponent, signed |
| y_sig | input | 24 | Multiplier significand, hidden bit at 23 |
| y_exp | input | 10 | Multiplier unbiased exponent, signed |
| z_sig | input | 24 | Addend significand, hidden bit at 23 |
| z_exp | input | 10 | Addend unbiased exponent, signed |
| prod_neg | input | 1 | Effective sign of the product |
| z_neg | input | 1 | Sign of the addend |
| z_zero | input | 1 | Addend is zero |
| rnd_down | input | 1 | Rounding mode is toward negative |
| busy | output | 1 | High outside `ST_IDLE` |
| done | output | 1 | Result valid pulse |
| res_neg | output | 1 | Result sign |
| res_exp | output | 12 | Result unbiased exponent, signed |
| res_sig | output | 27 | Result significand with guard, round, sticky |
| res_zero | output | 1 | Result is exactly zero |

## Verification
Alignment sticky and post-subtraction normalization can act on the same operation. This happens when an addend of opposite sign sits 30 binades above the product, or when the product sits 100 binades above a negative addend. The shifted-out bits then become sticky, and the borrow they cause makes the left shift pull ones up into the output field. The expected significand (0x7FFFFFF) and the exponent lowered by exactly one are derived by hand. A second overlap is a new `start` arriving while an operation is in flight. That pulse is injected two cycles into a run, and the check confirms that the first operation's result appears on time and that no second `done` follows.

// File: rtl/fma_sig_pkg.sv
package fma_sig_pkg;

    localparam int WORD_W = 64;
    localparam int LEAD   = 62;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ALIGN,
        ST_MERGE,
        ST_NORM,
        ST_DONE
    } fma_state_e;

    // Right shift with every lost one folded into bit 0.
    function automatic logic [63:0] jam_shr(input logic [63:0] w, input logic [6:0] n);
        logic [63:0] mask;
        logic [63:0] r;
        if (n >= 7'd63) begin
            r = {63'd0, |w};
        end else begin
            mask = (64'd1 << n) - 64'd1;
            r    = (w >> n) | {63'd0, |(w & mask)};
        end
        return r;
    endfunction

endpackage

// File: rtl/fma_prod.sv
module fma_prod import fma_sig_pkg::*; #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 10,
    parameter int EI    = EXP_W + 2
) (
    input  logic [SIG_W-1:0]        a_sig,
    input  logic [SIG_W-1:0]        b_sig,
    input  logic signed [EXP_W-1:0] a_exp,
    input  logic signed [EXP_W-1:0] b_exp,
    output logic [63:0]             word,
    output logic signed [EI-1:0]    exp
);
    localparam int PROD_W = 2 * SIG_W;
    localparam int UP     = WORD_W - PROD_W;

    logic [PROD_W-1:0]    prod;
    logic [63:0]          raw;
    logic signed [EI-1:0] esum;

    always_comb begin
        prod = PROD_W'(a_sig) * PROD_W'(b_sig);
        raw  = {prod, {UP{1'b0}}};
        esum = EI'(a_exp) + EI'(b_exp);
        if (raw[63]) begin
            word = jam_shr(raw, 7'd1);
            exp  = esum + EI'(1);
        end else begin
            word = raw;
            exp  = esum;
        end
    end
endmodule

// File: rtl/fma_align.sv
module fma_align import fma_sig_pkg::*; #(
    parameter int EI = 12
) (
    input  logic [63:0]          pw,
    input  logic signed [EI-1:0] pe,
    input  logic [63:0]          zw,
    input  logic signed [EI-1:0] ze,
    input  logic                 zz,
    output logic [63:0]          pw_o,
    output logic [63:0]          zw_o,
    output logic signed [EI-1:0] ce
);
    logic signed [EI:0] diff;
    logic [EI:0]        mag;
    logic [6:0]         n;

    always_comb begin
        diff = (EI+1)'(ze) - (EI+1)'(pe);
        mag  = diff[EI] ? -diff : diff;
        n    = (mag >= (EI+1)'(63)) ? 7'd63 : mag[6:0];
        pw_o = pw;
        zw_o = zw;
        ce   = pe;
        if (!zz) begin
            if (diff > 0) begin
                pw_o = jam_shr(pw, n);
                ce   = ze;
            end else begin
                zw_o = jam_shr(zw, n);
            end
        end
    end
endmodule

// File: rtl/fma_merge.sv
module fma_merge import fma_sig_pkg::*; #(
    parameter int EI = 12
) (
    input  logic [63:0]          pw,
    input  logic [63:0]          zw,
    input  logic                 ps,
    input  logic                 zs,
    input  logic                 zz,
    input  logic                 rd,
    input  logic signed [EI-1:0] ce,
    output logic [63:0]          w,
    output logic                 s,
    output logic signed [EI-1:0] e,
    output logic                 zero
);
    logic [63:0] sum;

    always_comb begin
        sum  = pw + zw;
        w    = pw;
        s    = ps;
        e    = ce;
        zero = 1'b0;
        if (zz) begin
            w = pw;
        end else if (ps == zs) begin
            if (sum[63]) begin
                w = jam_shr(sum, 7'd1);
                e = ce + EI'(1);
            end else begin
                w = sum;
            end
        end else begin
            if (zw >= pw) begin
                w = zw - pw;
                s = zs;
            end else begin
                w = pw - zw;
                s = ps;
            end
            if (w == 64'd0) begin
                zero = 1'b1;
                s    = rd;
                e    = '0;
            end
        end
    end
endmodule

// File: rtl/fma_norm.sv
module fma_norm import fma_sig_pkg::*; #(
    parameter int EI    = 12,
    parameter int OUT_W = 27
) (
    input  logic [63:0]          w,
    input  logic signed [EI-1:0] e,
    input  logic                 zero,
    output logic [OUT_W-1:0]     sig,
    output logic signed [EI-1:0] exp
);
    localparam int OUT_SHIFT = LEAD - (OUT_W - 1);

    logic [5:0]  msb;
    logic [5:0]  lz;
    logic [63:0] wn;
    logic [63:0] wo;

    always_comb begin
        msb = '0;
        for (int i = 0; i < LEAD + 1; i++) begin
            if (w[i]) msb = 6'(i);
        end
        lz = 6'(LEAD) - msb;
        wn = w << lz;
        wo = jam_shr(wn, 7'(OUT_SHIFT));
        if (zero) begin
            sig = '0;
            exp = '0;
        end else begin
            sig = wo[OUT_W-1:0];
            exp = e - EI'(lz);
        end
    end
endmodule

// File: rtl/fma_sig_core.sv
module fma_sig_core import fma_sig_pkg::*; #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SIG_W-1:0]        x_sig,
    input  logic signed [EXP_W-1:0] x_exp,
    input  logic [SIG_W-1:0]        y_sig,
    input  logic signed [EXP_W-1:0] y_exp,
    input  logic [SIG_W-1:0]        z_sig,
    input  logic signed [EXP_W-1:0] z_exp,
    input  logic                    prod_neg,
    input  logic                    z_neg,
    input  logic                    z_zero,
    input  logic                    rnd_down,
    output logic                    busy,
    output logic                    done,
    output logic                    res_neg,
    output logic signed [EXP_W+1:0] res_exp,
    output logic [SIG_W+2:0]        res_sig,
    output logic                    res_zero
);
    localparam int EI    = EXP_W + 2;
    localparam int OUT_W = SIG_W + 3;
    localparam int ZPAD  = WORD_W - 1 - SIG_W;

    fma_state_e state_q, state_d;

    // captured operands
    logic [SIG_W-1:0]        xs_q, ys_q;
    logic signed [EXP_W-1:0] xe_q, ye_q;
    logic [63:0]             zw_q;
    logic signed [EI-1:0]    ze_q;
    logic                    ps_q, zs_q, zz_q, rd_q;
    // stage registers
    logic [63:0]             p_w_q, a_pw_q, a_zw_q, m_w_q;
    logic signed [EI-1:0]    p_e_q, a_e_q, m_e_q;
    logic                    m_s_q, m_zero_q;

    // stage outputs
    logic [63:0]             p_w, a_pw, a_zw, m_w;
    logic signed [EI-1:0]    p_e, a_e, m_e, n_e;
    logic                    m_s, m_zero;
    logic [OUT_W-1:0]        n_sig;

    fma_prod #(.SIG_W(SIG_W), .EXP_W(EXP_W), .EI(EI)) u_prod (
        .a_sig(xs_q), .b_sig(ys_q), .a_exp(xe_q), .b_exp(ye_q),
        .word(p_w), .exp(p_e)
    );

    fma_align #(.EI(EI)) u_align (
        .pw(p_w_q), .pe(p_e_q), .zw(zw_q), .ze(ze_q), .zz(zz_q),
        .pw_o(a_pw), .zw_o(a_zw), .ce(a_e)
    );

    fma_merge #(.EI(EI)) u_merge (
        .pw(a_pw_q), .zw(a_zw_q), .ps(ps_q), .zs(zs_q), .zz(zz_q), .rd(rd_q),
        .ce(a_e_q), .w(m_w), .s(m_s), .e(m_e), .zero(m_zero)
    );

    fma_norm #(.EI(EI), .OUT_W(OUT_W)) u_norm (
        .w(m_w_q), .e(m_e_q), .zero(m_zero_q), .sig(n_sig), .exp(n_e)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MUL;
            ST_MUL:   state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_MERGE;
            ST_MERGE: state_d = ST_NORM;
            ST_NORM:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs_q <= '0; ys_q <= '0; xe_q <= '0; ye_q <= '0;
            zw_q <= '0; ze_q <= '0;
            ps_q <= 1'b0; zs_q <= 1'b0; zz_q <= 1'b0; rd_q <= 1'b0;
            p_w_q <= '0; p_e_q <= '0;
            a_pw_q <= '0; a_zw_q <= '0; a_e_q <= '0;
            m_w_q <= '0; m_e_q <= '0; m_s_q <= 1'b0; m_zero_q <= 1'b0;
            res_neg <= 1'b0; res_exp <= '0; res_sig <= '0; res_zero <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    xs_q <= x_sig; ys_q <= y_sig;
                    xe_q <= x_exp; ye_q <= y_exp;
                    zw_q <= z_zero ? 64'd0 : {1'b0, z_sig, {ZPAD{1'b0}}};
                    ze_q <= EI'(z_exp);
                    ps_q <= prod_neg; zs_q <= z_neg;
                    zz_q <= z_zero;   rd_q <= rnd_down;
                end
                ST_MUL: begin
                    p_w_q <= p_w; p_e_q <= p_e;
                end
                ST_ALIGN: begin
                    a_pw_q <= a_pw; a_zw_q <= a_zw; a_e_q <= a_e;
                end
                ST_MERGE: begin
                    m_w_q <= m_w; m_e_q <= m_e; m_s_q <= m_s; m_zero_q <= m_zero;
                end
                ST_NORM: begin
                    res_neg  <= m_s_q;
                    res_exp  <= n_e;
                    res_sig  <= n_sig;
                    res_zero <= m_zero_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    AST_ALIGN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MERGE && !zz_q) |-> (a_pw_q[LEAD] || a_zw_q[LEAD])); // R3
    AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM) |-> !m_w_q[63]); // R5
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_zero) |-> (res_sig == '0)); // R7
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_zero) |-> res_sig[OUT_W-1]); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORM) |=> ($stable(res_sig) && $stable(res_exp))); // R10
endmodule

// File: tb/fma_sig_core_test.sv
module fma_sig_core_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] xs; logic [9:0] xe;
        logic [23:0] ys; logic [9:0] ye;
        logic [23:0] zs; logic [9:0] ze;
        logic pn; logic zn; logic zz; logic rd;
        logic en; logic [11:0] ee; logic [26:0] es; logic ez;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h000000, 10'd0,   1'b0,1'b0,1'b1,1'b0, 1'b0, 12'd0,   27'h4000000, 1'b0, 4'd2},  // R2
        '{24'hC00000, 10'd0,   24'hC00000, 10'd0, 24'h000000, 10'd0,   1'b0,1'b0,1'b1,1'b0, 1'b0, 12'd1,   27'h4800000, 1'b0, 4'd1},  // R1
        '{24'hFFFFFF, 10'd0,   24'hFFFFFF, 10'd0, 24'hABCDEF, 10'd7,   1'b1,1'b0,1'b1,1'b0, 1'b1, 12'd1,   27'h7FFFFF1, 1'b0, 4'd9},  // R9 R2
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd0,   1'b0,1'b0,1'b0,1'b0, 1'b0, 12'd1,   27'h4000000, 1'b0, 4'd5},  // R5
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd0,   1'b0,1'b1,1'b0,1'b0, 1'b0, 12'd0,   27'h0,       1'b1, 4'd7},  // R7
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd0,   1'b0,1'b1,1'b0,1'b1, 1'b1, 12'd0,   27'h0,       1'b1, 4'd7},  // R7
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'hC00000, 10'd0,   1'b0,1'b1,1'b0,1'b0, 1'b1, 12'hFFF, 27'h4000000, 1'b0, 4'd6},  // R6
        '{24'hC00000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd0,   1'b1,1'b0,1'b0,1'b0, 1'b1, 12'hFFF, 27'h4000000, 1'b0, 4'd6},  // R6
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd30,  1'b0,1'b0,1'b0,1'b0, 1'b0, 12'd30,  27'h4000001, 1'b0, 4'd3},  // R3
        '{24'h800000, 10'd5,   24'h800000, 10'd0, 24'h800000, 10'd3,   1'b0,1'b0,1'b0,1'b0, 1'b0, 12'd5,   27'h5000000, 1'b0, 4'd3},  // R3
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd100, 1'b0,1'b0,1'b0,1'b0, 1'b0, 12'd100, 27'h4000001, 1'b0, 4'd4},  // R4
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800001, 10'd0,   1'b0,1'b1,1'b0,1'b0, 1'b1, 12'hFE9, 27'h4000000, 1'b0, 4'd8},  // R8
        '{24'h800000, 10'd0,   24'h800000, 10'd0, 24'h800000, 10'd30,  1'b0,1'b1,1'b0,1'b0, 1'b1, 12'd29,  27'h7FFFFFF, 1'b0, 4'd8},  // R8 R3
        '{24'h800000, 10'd100, 24'h800000, 10'd0, 24'h800000, 10'd0,   1'b0,1'b1,1'b0,1'b0, 1'b0, 12'd99,  27'h7FFFFFF, 1'b0, 4'd4}   // R4 R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [23:0] x_sig = '0, y_sig = '0, z_sig = '0;
    logic signed [9:0] x_exp = '0, y_exp = '0, z_exp = '0;
    logic prod_neg = 1'b0, z_neg = 1'b0, z_zero = 1'b0, rnd_down = 1'b0;
    logic busy, done, res_neg, res_zero;
    logic signed [11:0] res_exp;
    logic [26:0] res_sig;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_sig_core uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_sig(x_sig), .x_exp(x_exp), .y_sig(y_sig), .y_exp(y_exp),
        .z_sig(z_sig), .z_exp(z_exp), .prod_neg(prod_neg), .z_neg(z_neg),
        .z_zero(z_zero), .rnd_down(rnd_down), .busy(busy), .done(done),
        .res_neg(res_neg), .res_exp(res_exp), .res_sig(res_sig), .res_zero(res_zero)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        x_sig = v.xs; x_exp = v.xe; y_sig = v.ys; y_exp = v.ye;
        z_sig = v.zs; z_exp = v.ze; prod_neg = v.pn; z_neg = v.zn;
        z_zero = v.zz; rnd_down = v.rd;
    endtask

    task automatic run(input vec_t v, output int lat);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_res(input vec_t v, input string tag);
        check(res_neg === v.en, $sformatf("R%0d %s sign", v.req, tag), 64'(res_neg), 64'(v.en));
        check(res_exp === v.ee, $sformatf("R%0d %s exp", v.req, tag), 64'(res_exp), 64'(v.ee));
        check(res_sig === v.es, $sformatf("R%0d %s sig", v.req, tag), 64'(res_sig), 64'(v.es));
        check(res_zero === v.ez, $sformatf("R%0d %s zero", v.req, tag), 64'(res_zero), 64'(v.ez));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL R10 watchdog actual=%0d expected=<100000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        vec_t hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(busy === 1'b0 && done === 1'b0, "R11 reset handshake", {62'd0, busy, done}, 64'd0);
        check(res_sig === '0 && res_exp === '0 && res_neg === 1'b0 && res_zero === 1'b0,
              "R11 reset outputs", 64'(res_sig), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(TBL[i], lat);
            check(done === 1'b1, $sformatf("R10 done row %0d", i), 64'(done), 64'd1);
            check_res(TBL[i], $sformatf("row %0d", i));
            if (i == 0) check(lat == 5, "R10 latency", 64'(lat), 64'd5);
            @(negedge clk);
            check(done === 1'b0, "R10 single-cycle done", 64'(done), 64'd0);
        end

        // R2: addend fields ignored when z_zero, even with a huge exponent
        hold = TBL[0];
        hold.zs = 24'hFFFFFF; hold.ze = 10'd200; hold.zn = 1'b1;
        run(hold, lat);
        check_res(hold, "zero addend ignored");

        // R10: start during busy is ignored
        @(negedge clk);
        drive(TBL[1]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        drive(TBL[3]);
        start = 1'b1;
        check(busy === 1'b1, "R10 busy in flight", 64'(busy), 64'd1);
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 5, "R10 latency with stray start", 64'(lat), 64'd5);
        check_res(TBL[1], "stray start");
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) lat++;
        end
        check(lat == 0, "R10 no second done", 64'(lat), 64'd0);
        // R10: outputs hold after done
        check_res(TBL[1], "hold");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule